// File: doc/BRIEF.md
# Digital Loss-of-Signal Defect Detector

This block watches the recovered pulse stream of one receive channel of a DS3 or STS-1 line interface and decides whether a loss-of-signal defect is present. A clock enable marks each bit period, and a companion flag says whether a pulse arrived in that period. The defect is raised after a long unbroken run of empty bit periods. It is dropped only after a fixed-length window shows enough pulse density, so raising and dropping follow different rules.

The digital decision is merged with an analog-detector flag that is produced elsewhere and already has its own hysteresis. Three registered, read-only status bits come out: digital defect, analog defect, and the combined receive defect, which is the OR of the two. After reset the channel is taken to be in defect until a valid signal has been shown.

Top module: `los_digital_detector`

## Requirements
- R1: While the defect is clear, DECLARE_RUN (default 160) consecutive enabled bit periods with no pulse raise the digital defect at the end of the last of them.
- R2: A pulse in any enabled bit period restarts the empty-period run, so a run of DECLARE_RUN-1 empty periods followed by a pulse leaves the defect clear.
- R3: While the defect is raised, enabled bit periods are grouped into windows of WIN_LEN (default 32); at the end of a window holding at least CLEAR_MIN (default 11) pulses the digital defect drops.
- R4: A window holding fewer than CLEAR_MIN pulses leaves the defect raised, and the next window starts counting from zero.
- R5: The analog flag is sampled on each enabled bit period and shown unchanged on los_status[2].
- R6: los_status[1] is the OR of the digital and analog defect states.
- R7: Encoding of los_status: bit 0 digital defect, bit 1 combined defect, bit 2 analog defect; 1 means the defect is declared, 0 means it is not.
- R8: A synchronous active-high reset sets los_status to 3'b011 (digital and combined declared, analog clear) with both counters at zero.
- R9: State and los_status change only on cycles where bit_en is high; pulse_in and analog_los_in are ignored otherwise.
- R10: The empty-period counter saturates and does not wrap while the defect is raised, and restarts from zero when the defect drops, so a fresh full run is needed to raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High for one cycle per bit period |
| pulse_in | input | 1 | Pulse present in this bit period |
| analog_los_in | input | 1 | Analog detector defect flag |
| los_status | output | 3 | Registered status bits, encoding per R7 |

## Verification
The bench aims at the exact thresholds: a window with exactly CLEAR_MIN pulses must clear while one with one fewer must not, and DECLARE_RUN-1 empty periods must stay clear while DECLARE_RUN must raise the defect; an off-by-one counter would flip one of these outcomes. It checks that a cleared channel needs a whole fresh empty run before raising again, which a design leaving the run counter saturated would miss by raising at once. Long idle stretches with bit_en low and toggling inputs catch a design that advances on every clock, and a mid-run reset catches a wrong reset value.

// File: rtl/los_det_pkg.sv
package los_det_pkg;
  // Status bit positions (R7)
  localparam int unsigned ST_DIG  = 0;
  localparam int unsigned ST_COMB = 1;
  localparam int unsigned ST_ANA  = 2;
  localparam int unsigned ST_W    = 3;

  typedef logic [ST_W-1:0] los_status_t;

  // Reset value: digital and combined declared, analog clear (R8)
  localparam los_status_t ST_RESET = 3'b011;

  typedef enum logic {
    DET_CLEAR    = 1'b0,
    DET_DECLARED = 1'b1
  } det_state_e;
endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int unsigned DECLARE_RUN = 160,
  localparam int unsigned RUN_W = $clog2(DECLARE_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             restart,
  input  logic             pulse,
  output logic             run_hit,
  output logic [RUN_W-1:0] run_cnt
);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(DECLARE_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(DECLARE_RUN);

  logic [RUN_W-1:0] cnt_q;

  // The empty period that completes the run
  assign run_hit = cnt_en && !pulse && (cnt_q == RUN_LAST);
  assign run_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      if (pulse) begin
        cnt_q <= '0;
      end else if (cnt_q != RUN_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/los_density_win.sv
module los_density_win #(
  parameter int unsigned WIN_LEN   = 32,
  parameter int unsigned CLEAR_MIN = 11,
  localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1,
  localparam int unsigned PC_W  = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_en,
  input  logic             pulse,
  output logic             win_end,
  output logic             win_pass,
  output logic [WIN_W-1:0] win_pos
);
  localparam logic [WIN_W-1:0] POS_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [PC_W-1:0]  NEED     = PC_W'(CLEAR_MIN);

  logic [WIN_W-1:0] pos_q;
  logic [PC_W-1:0]  pcnt_q;
  logic [PC_W-1:0]  pcnt_total;

  assign pcnt_total = pcnt_q + PC_W'(pulse);
  assign win_end    = win_en && (pos_q == POS_LAST);
  assign win_pass   = win_end && (pcnt_total >= NEED);
  assign win_pos    = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      pcnt_q <= '0;
    end else if (!win_en) begin
      pos_q  <= pos_q;
      pcnt_q <= pcnt_q;
    end else if (win_end) begin
      pos_q  <= '0;
      pcnt_q <= '0;
    end else begin
      pos_q  <= pos_q + 1'b1;
      pcnt_q <= pcnt_total;
    end
  end
endmodule

// File: rtl/los_digital_detector.sv
module los_digital_detector
  import los_det_pkg::*;
#(
  parameter int unsigned DECLARE_RUN = 160,
  parameter int unsigned WIN_LEN     = 32,
  parameter int unsigned CLEAR_MIN   = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       pulse_in,
  input  logic       analog_los_in,
  output logic [2:0] los_status
);
  localparam int unsigned RUN_W = $clog2(DECLARE_RUN + 1);
  localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  det_state_e       state_q, state_d;
  los_status_t      status_q;
  logic             run_hit;
  logic [RUN_W-1:0] run_cnt;
  logic             win_end;
  logic             win_pass;
  logic [WIN_W-1:0] win_pos;
  logic             dig_d;

  los_zero_run #(.DECLARE_RUN(DECLARE_RUN)) u_run (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (bit_en && (state_q == DET_CLEAR)),
    .restart (win_pass),
    .pulse   (pulse_in),
    .run_hit (run_hit),
    .run_cnt (run_cnt)
  );

  los_density_win #(.WIN_LEN(WIN_LEN), .CLEAR_MIN(CLEAR_MIN)) u_win (
    .clk      (clk),
    .rst      (rst),
    .win_en   (bit_en && (state_q == DET_DECLARED)),
    .pulse    (pulse_in),
    .win_end  (win_end),
    .win_pass (win_pass),
    .win_pos  (win_pos)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DET_CLEAR:    if (run_hit)  state_d = DET_DECLARED;
      DET_DECLARED: if (win_pass) state_d = DET_CLEAR;
      default:      state_d = DET_DECLARED;
    endcase
  end

  assign dig_d = (state_d == DET_DECLARED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= DET_DECLARED;
      status_q <= ST_RESET;
    end else if (bit_en) begin
      state_q           <= state_d;
      status_q[ST_DIG]  <= dig_d;
      status_q[ST_ANA]  <= analog_los_in;
      status_q[ST_COMB] <= dig_d | analog_los_in;
    end
  end

  assign los_status = status_q;
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk #(
  parameter int unsigned DECLARE_RUN = 160,
  parameter int unsigned WIN_LEN     = 32,
  parameter int unsigned CLEAR_MIN   = 11,
  localparam int unsigned RUN_W = $clog2(DECLARE_RUN + 1),
  localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             pulse_in,
  input logic [2:0]       los_status,
  input logic [RUN_W-1:0] run_cnt,
  input logic [WIN_W-1:0] win_pos
);
  // R6
  comb_or_chk: assert property (@(posedge clk) disable iff (rst)
    los_status[1] == (los_status[0] | los_status[2]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_en) && !$past(rst)) |-> $stable(los_status));

  // R1
  declare_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(los_status[0]) |-> ($past(bit_en) && !$past(pulse_in)));

  // R3
  clear_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(los_status[0]) |-> ($past(bit_en) && ($past(win_pos) == WIN_W'(WIN_LEN - 1))));

  // R10
  run_sat_chk: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RUN_W'(DECLARE_RUN));

  // R10
  run_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(los_status[0]) |-> (run_cnt == '0));
endmodule

bind los_digital_detector los_detector_chk #(
  .DECLARE_RUN(DECLARE_RUN),
  .WIN_LEN    (WIN_LEN),
  .CLEAR_MIN  (CLEAR_MIN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .pulse_in   (pulse_in),
  .los_status (los_status),
  .run_cnt    (run_cnt),
  .win_pos    (win_pos)
);

// File: tb/los_digital_detector_test.sv
module los_digital_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 10;

  // Segment table: length, pulses in leading periods, analog flag, expected status
  localparam int          SEG_LEN [NSEG] = '{32, 159, 1, 160, 32, 32, 10, 150, 32, 16};
  localparam int          SEG_NP  [NSEG] = '{11,   0, 1,   0, 10, 32,  0,   0, 11,  0};
  localparam logic        SEG_ANA [NSEG] = '{0,    0, 0,   0,  0,  0,  1,   1,  0,  0};
  localparam logic [2:0]  SEG_EXP [NSEG] = '{3'b000, 3'b000, 3'b000, 3'b011, 3'b011,
                                             3'b000, 3'b110, 3'b111, 3'b000, 3'b000};
  localparam string       SEG_REQ [NSEG] = '{"R3 exact-min window clears",
                                             "R2 run one short stays clear",
                                             "R2 pulse restarts run",
                                             "R1 full empty run declares",
                                             "R4 one-short window holds",
                                             "R3 dense window clears",
                                             "R10 run restarted after clear; R5 analog",
                                             "R1 R6 R7 both declared",
                                             "R3 clear with analog dropped",
                                             "R2 short run after clear"};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       pulse_in = 1'b0;
  logic       analog_los_in = 1'b0;
  logic [2:0] los_status;
  int         nrun = 0;
  int         nfail = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  los_digital_detector uut (
    .clk           (clk),
    .rst           (rst),
    .bit_en        (bit_en),
    .pulse_in      (pulse_in),
    .analog_los_in (analog_los_in),
    .los_status    (los_status)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    nrun++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic en, input logic p, input logic a);
    bit_en = en;
    pulse_in = p;
    analog_los_in = a;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nrun++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check("R8 reset status", los_status, 3'b011);
    rst = 1'b0;

    // R7 R8: held in declared state with no signal
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0);
    check("R8 starts declared, empty window keeps it", los_status, 3'b011);

    // Re-align to a fresh window via reset
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int s = 0; s < NSEG; s++) begin
      for (int i = 0; i < SEG_LEN[s]; i++)
        step(1'b1, (i < SEG_NP[s]), SEG_ANA[s]);
      check(SEG_REQ[s], los_status, SEG_EXP[s]);
    end

    // R9: idle periods with toggling inputs change nothing (run at 16, clear)
    for (int i = 0; i < 300; i++) step(1'b0, i[0], 1'b1);
    check("R9 inputs ignored without bit_en", los_status, 3'b000);

    // R9: 143 more empty enabled periods with gaps -> 159 total, still clear
    for (int i = 0; i < 143; i++) begin
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b1);
    end
    check("R9 R2 gapped run one short", los_status, 3'b000);
    step(1'b1, 1'b0, 1'b0);
    check("R1 gapped run completes", los_status, 3'b011);

    // R5: analog alone is reported on bit 2 and bit 1 stays 1
    step(1'b1, 1'b0, 1'b1);
    check("R5 analog sampled while declared", los_status, 3'b111);

    // R8: reset in mid-run of a clear channel
    for (int i = 0; i < 32; i++) step(1'b1, 1'b1, 1'b0);
    check("R3 full density clears", los_status, 3'b000);
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1);
    rst = 1'b0;
    check("R8 mid-run reset", los_status, 3'b011);

    finish_run();
  end
endmodule